// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits in the read path of a byte-wide non-volatile store. While the store runs its internal program cycle, it alters the data returned on reads so that software can tell when the cycle has finished. It offers two ways to poll.

The first is the inverted-top-bit method. A read of the byte most recently written returns the complement of that byte's top bit until programming ends. The second is the toggle method. The bit just below the top alternates on every read taken while busy. Outside a program cycle, reads return the array contents untouched.

The write controller supplies a busy level and a strobe for each byte write. The strobe carries a lock flag that marks writes refused by write protection. A refused write is not remembered, and it disarms the inverted-top-bit indication. Array read data comes in alongside each read request. The result leaves through a register one cycle later. The reset input asserts asynchronously and its release is synchronised to the clock.

Top module: `wcs_top`

## Requirements
- R1: After reset, `rd_valid_o` is 0 and `rd_data_o` is all zeros, and the toggle bit starts at 0, so the first read taken while busy returns 0 on bit DW-2.
- R2: With `busy_i` low, a read requested in cycle n returns `arr_q_i` unmodified on `rd_data_o`, with `rd_valid_o` high, in cycle n+1.
- R3: With `busy_i` high, a read whose address equals the last accepted write address returns the complement of that write's bit DW-1 on bit DW-1.
- R4: With `busy_i` high, a read at any other address, or while no accepted write is remembered, returns `arr_q_i` bit DW-1 on bit DW-1.
- R5: With `busy_i` high, bit DW-2 of each read is the inverse of the value returned by the previous busy read.
- R6: With `busy_i` high, bits DW-3 down to 0 of the read data are 0.
- R7: Reads taken with `busy_i` low do not advance the toggle bit.
- R8: A write strobe with `wr_lock_i` high is not remembered and disarms the inverted-top-bit indication until the next accepted write.
- R9: A later accepted write replaces the remembered address and data.
- R10: In a cycle following one with no read request, `rd_data_o` keeps its value and `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Internal program cycle running |
| wr_en_i | input | 1 | Byte write strobe |
| wr_lock_i | input | 1 | Write refused by protection (qualifies wr_en_i) |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read address |
| arr_q_i | input | DW | Array data for the requested address |
| rd_data_o | output | DW | Read result, registered |
| rd_valid_o | output | 1 | Read result valid |

## Verification
The bench builds the block with AW=4 and DW=8. With these values it can write every one of the 16 addresses as the remembered byte, with both top-bit values. After each write it sweeps busy reads over all 16 addresses. That covers every match and mismatch pair for the top-bit rule. The same sweep runs a long toggle sequence whose expected parity is counted in the bench. Separate short sequences cover refused writes, idle reads between busy phases, and the hold behaviour when no read is requested.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic {
    VIEW_ARRAY  = 1'b0,
    VIEW_STATUS = 1'b1
  } view_e;
endpackage

// File: rtl/wcs_last_write.sv
module wcs_last_write #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_lock_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          armed_o,
  output logic [AW-1:0] addr_o,
  output logic          msb_o
);
  localparam int MSB = DW - 1;

  logic          armed_q, armed_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          msb_q, msb_d;
  logic          take;

  assign take = wr_en_i & ~wr_lock_i;

  always_comb begin
    armed_d = armed_q;
    addr_d  = addr_q;
    msb_d   = msb_q;
    if (wr_en_i) begin
      armed_d = take;
    end
    if (take) begin
      addr_d = wr_addr_i;
      msb_d  = wr_data_i[MSB];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
      msb_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      addr_q  <= addr_d;
      msb_q   <= msb_d;
    end
  end

  assign armed_o = armed_q;
  assign addr_o  = addr_q;
  assign msb_o   = msb_q;

  // R8: a refused write leaves the indication disarmed
  p_lock_disarms_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && wr_lock_i) |=> !armed_o);

  // R9: an accepted write is remembered
  p_take_records_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && !wr_lock_i) |=> (armed_o && addr_o == $past(wr_addr_i)));
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk,
  input  logic rst_ni,
  input  logic step_i,
  output logic tgl_o
);
  logic tgl_q, tgl_d;

  always_comb begin
    tgl_d = tgl_q;
    if (step_i) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;

  // R5: each busy read flips the bit
  p_flip_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    step_i |=> (tgl_o != $past(tgl_o)));

  // R7: no busy read, no change
  p_still_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !step_i |=> $stable(tgl_o));
endmodule

// File: rtl/wcs_read_port.sv
module wcs_read_port
  import wcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  view_e         view_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] arr_q_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  localparam int LOW_W = DW - 2;

  logic [DW-1:0] data_q, data_d;
  logic          vld_q, vld_d;

  always_comb begin
    vld_d  = rd_en_i;
    data_d = data_q;
    if (rd_en_i) begin
      data_d = (view_i == VIEW_STATUS) ? status_i : arr_q_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = vld_q;

  // R2: a request is answered one cycle later
  p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  // R10: no request, data held and not valid
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en_i |=> ($stable(rd_data_o) && !rd_valid_o));

  // R6: reserved status bits read as zero
  p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en_i && view_i == VIEW_STATUS) |=> (rd_data_o[LOW_W-1:0] == '0));
endmodule

// File: rtl/wcs_top.sv
module wcs_top
  import wcs_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          wr_en_i,
  input  logic          wr_lock_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_q_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TGL_BIT  = DW - 2;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          armed;
  logic [AW-1:0] last_addr;
  logic          last_msb;
  logic          tgl;
  logic          hit;
  logic [DW-1:0] status_word;
  view_e         view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  wcs_last_write #(.AW(AW), .DW(DW)) u_last (
    .clk(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_lock_i(wr_lock_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .armed_o(armed), .addr_o(last_addr), .msb_o(last_msb)
  );

  wcs_toggle u_tgl (
    .clk(clk), .rst_ni(rst_ni),
    .step_i(rd_en_i & busy_i),
    .tgl_o(tgl)
  );

  always_comb begin
    hit         = armed && (rd_addr_i == last_addr);
    status_word = '0;
    status_word[POLL_BIT] = hit ? ~last_msb : arr_q_i[POLL_BIT];
    status_word[TGL_BIT]  = tgl;
    view = busy_i ? VIEW_STATUS : VIEW_ARRAY;
  end

  wcs_read_port #(.DW(DW)) u_port (
    .clk(clk), .rst_ni(rst_ni),
    .rd_en_i(rd_en_i), .view_i(view),
    .status_i(status_word), .arr_q_i(arr_q_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  // R2: idle reads pass the array byte through
  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en_i && !busy_i) |=> (rd_data_o == $past(arr_q_i)));

  // R3: busy read of the remembered byte shows its inverted top bit
  p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en_i && busy_i && armed && rd_addr_i == last_addr)
      |=> (rd_data_o[POLL_BIT] == !$past(last_msb)));
endmodule

// File: tb/sim_wcs_top.sv
module sim_wcs_top;
  localparam int  AW = 4;
  localparam int  DW = 8;
  localparam time TCLK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          busy, wr_en, wr_lock, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, arr_q;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  int busy_reads = 0;
  logic [DW-1:0] got;
  logic          got_v;

  always #(TCLK/2) clk = ~clk;

  wcs_top #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .busy_i(busy),
    .wr_en_i(wr_en), .wr_lock_i(wr_lock),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .arr_q_i(arr_q),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // inputs change at negedge; results sampled at the following negedge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic lk);
    wr_en = 1'b1; wr_lock = lk; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_lock = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] q);
    rd_en = 1'b1; rd_addr = a; arr_q = q;
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data; got_v = rd_valid;
  endtask

  // busy read with full expected word
  task automatic busy_rd(input logic [AW-1:0] a, input logic [DW-1:0] q,
                         input bit exp_msb, input string req);
    logic [DW-1:0] e;
    e = '0;
    e[DW-1] = exp_msb;
    e[DW-2] = busy_reads[0];
    rd(a, q);
    busy_reads++;
    check(got == e && got_v, req, got, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; busy = 1'b0; wr_en = 1'b0; wr_lock = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; arr_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
    check(rd_data == '0, "R1 data", rd_data, 0);

    // R2: idle reads pass through, all addresses
    for (int a = 0; a < 16; a++) begin
      logic [DW-1:0] q;
      q = 8'(a * 37 + 5);
      rd(AW'(a), q);
      check(got == q && got_v, "R2 idle pass", got, q);
    end

    // R1: first busy read shows toggle 0; no write remembered yet -> R4
    busy = 1'b1;
    busy_rd(4'd2, 8'hFF, 1'b1, "R1 first toggle/R4 unarmed");
    busy_rd(4'd2, 8'h3F, 1'b0, "R4 unarmed low");

    // R3/R4/R5/R6: exhaustive remembered-address x read-address sweep
    for (int la = 0; la < 16; la++) begin
      for (int m = 0; m < 2; m++) begin
        logic [DW-1:0] wd;
        wd = {m[0], 7'(la * 5 + 1)};
        busy = 1'b0;
        wr(AW'(la), wd, 1'b0);
        busy = 1'b1;
        for (int ra = 0; ra < 16; ra++) begin
          logic [DW-1:0] q;
          q = 8'(ra * 29 + la * 3 + m);
          if (ra == la) busy_rd(AW'(ra), q, ~wd[DW-1], "R3 inverted top bit");
          else          busy_rd(AW'(ra), q, q[DW-1], "R4 mismatch passes top bit");
        end
      end
    end

    // R7: idle reads between busy phases do not advance the toggle
    busy = 1'b0;
    for (int k = 0; k < 3; k++) begin
      rd(4'd1, 8'h55);
      check(got == 8'h55, "R7 idle read plain", got, 8'h55);
    end
    busy = 1'b1;
    busy_rd(4'd1, 8'h00, 1'b0, "R7 toggle continues");

    // R8: refused write disarms and is not remembered
    busy = 1'b0;
    wr(4'd3, 8'h80, 1'b0);
    wr(4'd5, 8'h00, 1'b1);
    busy = 1'b1;
    busy_rd(4'd3, 8'h80, 1'b1, "R8 disarmed at old address");
    busy_rd(4'd5, 8'h00, 1'b0, "R8 locked address not remembered");

    // R9: later accepted write replaces the remembered byte
    busy = 1'b0;
    wr(4'd5, 8'h00, 1'b0);
    busy = 1'b1;
    busy_rd(4'd5, 8'h00, 1'b1, "R9 new address inverted");
    busy_rd(4'd3, 8'h80, 1'b1, "R9 old address plain");

    // R10: no request -> data held, valid low
    begin
      logic [DW-1:0] keep;
      busy = 1'b0;
      rd(4'd7, 8'hA5);
      keep = got;
      arr_q = 8'h5A; rd_addr = 4'd8;
      @(negedge clk);
      check(rd_data == keep, "R10 data held", rd_data, keep);
      check(rd_valid == 1'b0, "R10 valid low", rd_valid, 0);
    end

    summary();
  end
endmodule